// File: doc/BRIEF.md
# Regulator Power-Up Sequencer

This block is the digital sequencer that takes a multi-phase buck regulator from reset to a power-good state. It waits until both the enable input and the undervoltage-lockout-OK flag are true. It then runs a start delay and starts the phase oscillator. During the first oscillator cycles it raises a window strobe, which the phase-detection logic uses to find out how many phases are populated. After that it drives a digital reference code.

The reference runs in two stages, and it moves one code step for each ramp tick. First it climbs from zero to a fixed boot code. It holds that code for a settling interval while the externally programmed voltage code settles. At the end of the hold the sequencer captures the programmed code. The reference then moves up or down to the captured code, as needed. A further delay follows the arrival at the target, and only then is power-good raised. If either start condition drops at any time, the machine returns to idle on the next clock edge. Every output is then cleared.

All intervals are counted in clock cycles of `clk`, which also stands in for the oscillator clock. The reference code feeds an external DAC.

Top module: `pwrseq_top`

## Requirements
- R1: While `en_i` and `uv_ok_i` are not both high, and during reset, `osc_en_o`, `detect_o` and `pgood_o` are low, and `vref_o` and `vid_hold_o` are zero.
- R2: When both start conditions are first sampled high at clock edge E0, `osc_en_o` is low up to and including edge E0+TD1_CYC. It is high from edge E0+TD1_CYC+1 onward.
- R3: `detect_o` is high for exactly DET_CYC cycles, starting at the first cycle with `osc_en_o` high. It is never high while `osc_en_o` is low.
- R4: After the detection window, `vref_o` rises from zero to BOOT_CODE and never exceeds BOOT_CODE in this stage.
- R5: `vref_o` stays at BOOT_CODE for TD3_CYC+1 cycles after the edge on which it reaches BOOT_CODE. On the last of these edges (arrival edge + TD3_CYC + 1), `vid_hold_o` takes the value `vid_i` had in the cycle before. Before that edge it stays zero.
- R6: After the capture, `vref_o` moves toward `vid_hold_o`, up or down, and never leaves the range between BOOT_CODE and the captured code. Changes on `vid_i` after the capture have no effect on `vid_hold_o` or on the final reference.
- R7: `pgood_o` rises exactly TD5_CYC+1 edges after the later of two events: the capture, and `vref_o` first equalling the captured code. While high, `vref_o` equals `vid_hold_o`.
- R8: If either start condition is low in a cycle, then after the next edge `pgood_o`, `osc_en_o` and `detect_o` are low, and `vref_o` and `vid_hold_o` are zero.
- R9: `vref_o` changes only on an edge at which `tick_i` was high and both start conditions held, and then by exactly one code.
- R10: Once `pgood_o` is high, it stays high, and `vref_o` stays constant, for as long as both start conditions hold, whatever `vid_i` and `tick_i` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the oscillator time base |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Regulator enable |
| uv_ok_i | input | 1 | Supply above the undervoltage lockout level |
| vid_i | input | CW | Programmed output voltage code |
| tick_i | input | 1 | Ramp step strobe, one reference step per high cycle |
| osc_en_o | output | 1 | Phase oscillator enable |
| detect_o | output | 1 | Phase-detection window strobe |
| vref_o | output | CW | Reference code to the DAC |
| vid_hold_o | output | CW | Captured programmed code |
| pgood_o | output | 1 | Power-good flag |

## Verification
Several rules are checked by the assertions on every cycle. A dropped start condition clears everything on the next edge. The reference moves only on a tick, and by a single code. The strobe needs the oscillator. The boot stage never climbs past the boot code. The captured code stays put between capture events. Power-good implies that the reference sits on the captured code. The exact cycle counts of the start delay, the strobe width, the hold length, the capture instant and the power-good delay can only be shown by the bench's scenarios. So can the immunity to late code changes. The bench runs every target code of a 4-bit configuration, targets below, at and above the boot code, with three tick spacings, and it aborts the sequence both mid-ramp and after power-good.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE      = 3'd0,
    S_START_DLY = 3'd1,
    S_DETECT    = 3'd2,
    S_RAMP_BOOT = 3'd3,
    S_BOOT_HOLD = 3'd4,
    S_RAMP_TGT  = 3'd5,
    S_GOOD_DLY  = 3'd6,
    S_GOOD      = 3'd7
  } seq_state_e;

  function automatic logic osc_running(seq_state_e s);
    return (s != S_IDLE) && (s != S_START_DLY);
  endfunction

  function automatic logic ramping(seq_state_e s);
    return (s == S_RAMP_BOOT) || (s == S_RAMP_TGT);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [CNTW-1:0] load_val,
  output logic            expired_o
);
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pwrseq_ramp.sv
module pwrseq_ramp #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] tgt,
  output logic [CW-1:0] ref_o,
  output logic          at_tgt_o,
  output logic          step_o
);
  // One code toward the target, never past it
  function automatic logic [CW-1:0] step_toward(logic [CW-1:0] cur, logic [CW-1:0] goal);
    if (cur < goal) return cur + 1'b1;
    if (cur > goal) return cur - 1'b1;
    return cur;
  endfunction

  logic [CW-1:0] ref_q;

  assign at_tgt_o = (ref_q == tgt);
  assign step_o   = run && tick && !at_tgt_o;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ref_q <= '0;
    end else if (step_o) begin
      ref_q <= step_toward(ref_q, tgt);
    end
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int CNTW    = 4,
  parameter int TD1_CYC = 4,
  parameter int DET_CYC = 2,
  parameter int TD3_CYC = 8,
  parameter int TD5_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            tmr_expired,
  input  logic            at_tgt,
  output seq_state_e      state_o,
  output logic            tmr_load_o,
  output logic [CNTW-1:0] tmr_val_o,
  output logic            latch_o
);
  localparam logic [CNTW-1:0] TD1_LD = CNTW'(TD1_CYC - 1);
  localparam logic [CNTW-1:0] DET_LD = CNTW'(DET_CYC - 1);
  localparam logic [CNTW-1:0] TD3_LD = CNTW'(TD3_CYC - 1);
  localparam logic [CNTW-1:0] TD5_LD = CNTW'(TD5_CYC - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    latch_o    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        state_d    = S_START_DLY;
        tmr_load_o = 1'b1;
        tmr_val_o  = TD1_LD;
      end
      S_START_DLY: if (tmr_expired) begin
        state_d    = S_DETECT;
        tmr_load_o = 1'b1;
        tmr_val_o  = DET_LD;
      end
      S_DETECT: if (tmr_expired) state_d = S_RAMP_BOOT;
      S_RAMP_BOOT: if (at_tgt) begin
        state_d    = S_BOOT_HOLD;
        tmr_load_o = 1'b1;
        tmr_val_o  = TD3_LD;
      end
      S_BOOT_HOLD: if (tmr_expired) begin
        state_d = S_RAMP_TGT;
        latch_o = 1'b1;
      end
      S_RAMP_TGT: if (at_tgt) begin
        state_d    = S_GOOD_DLY;
        tmr_load_o = 1'b1;
        tmr_val_o  = TD5_LD;
      end
      S_GOOD_DLY: if (tmr_expired) state_d = S_GOOD;
      S_GOOD: state_d = S_GOOD;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !go) state_q <= S_IDLE;
    else               state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int CW        = 8,
  parameter int BOOT_CODE = 110,
  parameter int TD1_CYC   = 16,
  parameter int DET_CYC   = 2,
  parameter int TD3_CYC   = 64,
  parameter int TD5_CYC   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          uv_ok_i,
  input  logic [CW-1:0] vid_i,
  input  logic          tick_i,
  output logic          osc_en_o,
  output logic          detect_o,
  output logic [CW-1:0] vref_o,
  output logic [CW-1:0] vid_hold_o,
  output logic          pgood_o
);
  localparam int unsigned MAX_DLY = max2(max2(TD1_CYC, DET_CYC), max2(TD3_CYC, TD5_CYC));
  localparam int CNTW = $clog2(MAX_DLY + 1);
  localparam logic [CW-1:0] BOOT_LV = CW'(BOOT_CODE);

  // Named internal events, visible to the bound checker
  logic            go;
  seq_state_e      state;
  logic            tmr_load, tmr_expired;
  logic [CNTW-1:0] tmr_val;
  logic            latch_evt;
  logic            boot_phase;
  logic            ramp_run;
  logic            at_tgt;
  logic            step_evt;
  logic [CW-1:0]   ramp_tgt;
  logic [CW-1:0]   hold_q;

  assign go         = en_i && uv_ok_i;
  assign boot_phase = (state == S_RAMP_BOOT);
  assign ramp_run   = ramping(state);
  assign ramp_tgt   = boot_phase ? BOOT_LV : hold_q;

  pwrseq_fsm #(
    .CNTW(CNTW), .TD1_CYC(TD1_CYC), .DET_CYC(DET_CYC),
    .TD3_CYC(TD3_CYC), .TD5_CYC(TD5_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go),
    .tmr_expired(tmr_expired), .at_tgt(at_tgt),
    .state_o(state), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .latch_o(latch_evt)
  );

  pwrseq_timer #(.CNTW(CNTW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(!go),
    .load(tmr_load), .load_val(tmr_val), .expired_o(tmr_expired)
  );

  pwrseq_ramp #(.CW(CW)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr(!go), .run(ramp_run),
    .tick(tick_i), .tgt(ramp_tgt),
    .ref_o(vref_o), .at_tgt_o(at_tgt), .step_o(step_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !go) hold_q <= '0;
    else if (latch_evt) hold_q <= vid_i;
  end

  assign vid_hold_o = hold_q;
  assign osc_en_o   = osc_running(state);
  assign detect_o   = (state == S_DETECT);
  assign pgood_o    = (state == S_GOOD);
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int CW        = 8,
  parameter int BOOT_CODE = 110
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_i,
  input logic          uv_ok_i,
  input logic          tick_i,
  input logic [CW-1:0] vref_o,
  input logic [CW-1:0] vid_hold_o,
  input logic          osc_en_o,
  input logic          detect_o,
  input logic          pgood_o,
  input logic          boot_phase,
  input logic          latch_evt
);
  localparam logic [CW-1:0] BOOT_LV = CW'(BOOT_CODE);

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && uv_ok_i) |=> (!pgood_o && !osc_en_o && !detect_o && vref_o == '0 && vid_hold_o == '0)); // R8
  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && uv_ok_i && !tick_i) |=> $stable(vref_o)); // R9
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && uv_ok_i) |=> (vref_o == $past(vref_o) || vref_o == $past(vref_o) + 1'b1
                           || vref_o == $past(vref_o) - 1'b1)); // R9
  AST_DETECT_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    detect_o |-> osc_en_o); // R3
  AST_BOOT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    boot_phase |-> (vref_o <= BOOT_LV)); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && uv_ok_i && !latch_evt) |=> $stable(vid_hold_o)); // R6
  AST_PGOOD_ON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    pgood_o |-> (vref_o == vid_hold_o && osc_en_o && !detect_o)); // R7
  AST_PGOOD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood_o && en_i && uv_ok_i) |=> pgood_o); // R10
endmodule

bind pwrseq_top pwrseq_chk #(.CW(CW), .BOOT_CODE(BOOT_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .uv_ok_i(uv_ok_i), .tick_i(tick_i),
  .vref_o(vref_o), .vid_hold_o(vid_hold_o), .osc_en_o(osc_en_o),
  .detect_o(detect_o), .pgood_o(pgood_o), .boot_phase(boot_phase),
  .latch_evt(latch_evt)
);

// File: tb/pwrseq_top_test.sv
module pwrseq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4, BOOT = 6, TD1 = 3, DET = 2, TD3 = 4, TD5 = 5;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, uv = 1'b0, tick = 1'b0;
  logic [CW-1:0] vid = '0;
  logic osc_en, detect, pgood;
  logic [CW-1:0] vref, hold;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int tick_per = 1, tcnt = 0;
  logic tick_on = 1'b0;
  logic tick_at_edge = 1'b0, go_at_edge = 1'b0;
  logic [CW-1:0] prev_ref = '0;

  pwrseq_top #(.CW(CW), .BOOT_CODE(BOOT), .TD1_CYC(TD1), .DET_CYC(DET),
               .TD3_CYC(TD3), .TD5_CYC(TD5)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .uv_ok_i(uv), .vid_i(vid), .tick_i(tick),
    .osc_en_o(osc_en), .detect_o(detect), .vref_o(vref), .vid_hold_o(hold),
    .pgood_o(pgood));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // tick generator
  always @(negedge clk) begin
    if (tick_on) begin
      tick <= (tcnt == 0);
      tcnt <= (tcnt + 1 >= tick_per) ? 0 : tcnt + 1;
    end else tick <= 1'b0;
  end

  always @(posedge clk) begin
    tick_at_edge <= tick;
    go_at_edge   <= en && uv && rst_n;
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  // R9 monitor: a change needs a tick and is one code
  always @(negedge clk) begin
    if (go_at_edge && vref !== prev_ref) begin
      check(tick_at_edge && (int'(vref) - int'(prev_ref) == 1 || int'(prev_ref) - int'(vref) == 1),
            "R9 step", int'(vref), int'(prev_ref));
    end
    prev_ref = vref;
  end

  task automatic expect_idle(input string tag);
    check(!osc_en && !detect && !pgood && vref == '0 && hold == '0, tag,
          {osc_en, detect, pgood}, 0);
  endtask

  task automatic run_one(input int t, input int per);
    int lo, hi, guard;
    bit in_range;
    lo = (t < BOOT) ? t : BOOT;
    hi = (t < BOOT) ? BOOT : t;
    tick_per = per; tcnt = 0; tick_on = 1'b1;
    vid = CW'(~t);
    en = 1'b1; uv = 1'b1;
    repeat (TD1) @(negedge clk);
    check(!osc_en, "R2 osc still off", osc_en, 0);
    @(negedge clk);
    check(osc_en, "R2 osc on", osc_en, 1);
    check(detect, "R3 strobe first", detect, 1);
    @(negedge clk);
    check(detect, "R3 strobe second", detect, 1);
    @(negedge clk);
    check(!detect, "R3 strobe ends", detect, 0);
    // boot ramp (R4)
    guard = 0; in_range = 1'b1;
    while (vref != CW'(BOOT) && guard < 200) begin
      @(negedge clk); guard++;
      if (vref > CW'(BOOT)) in_range = 1'b0;
    end
    check(in_range && vref == CW'(BOOT), "R4 boot ramp", int'(vref), BOOT);
    // hold and capture (R5)
    vid = CW'(t);
    in_range = 1'b1;
    for (int j = 1; j <= TD3; j++) begin
      @(negedge clk);
      if (vref != CW'(BOOT) || hold != '0) in_range = 1'b0;
    end
    check(in_range, "R5 boot hold", int'(hold), 0);
    @(negedge clk);
    check(hold == CW'(t), "R5 capture", int'(hold), t);
    check(vref == CW'(BOOT), "R5 ref at capture", int'(vref), BOOT);
    vid = CW'(~t);
    // final ramp (R6)
    guard = 0; in_range = 1'b1;
    while (vref != CW'(t) && guard < 300) begin
      @(negedge clk); guard++;
      if (int'(vref) < lo || int'(vref) > hi) in_range = 1'b0;
    end
    check(in_range && vref == CW'(t) && hold == CW'(t), "R6 target ramp", int'(vref), t);
    // power-good delay (R7)
    repeat (TD5) @(negedge clk);
    check(!pgood, "R7 pgood early", pgood, 0);
    @(negedge clk);
    check(pgood && vref == CW'(t), "R7 pgood on time", pgood, 1);
    // R10: stays good while code input and ticks move
    in_range = 1'b1;
    for (int j = 0; j < 6; j++) begin
      vid = vid + CW'(3);
      @(negedge clk);
      if (!pgood || vref != CW'(t)) in_range = 1'b0;
    end
    check(in_range, "R10 pgood holds", int'(vref), t);
    // R8: drop undervoltage flag
    uv = 1'b0;
    @(negedge clk);
    expect_idle("R8 uv drop");
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int guard;
    repeat (3) @(negedge clk);
    expect_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;
    repeat (10) @(negedge clk);
    expect_idle("R1 enable alone");
    en = 1'b0; uv = 1'b1;
    repeat (10) @(negedge clk);
    expect_idle("R1 uv alone");
    uv = 1'b0;
    @(negedge clk);

    for (int t = 0; t < (1 << CW); t++) run_one(t, (t % 3) + 1);

    // R8: abort during the boot ramp, then a clean restart
    tick_per = 2; tick_on = 1'b1; vid = CW'(12);
    en = 1'b1; uv = 1'b1;
    guard = 0;
    while (vref != CW'(3) && guard < 200) begin
      @(negedge clk); guard++;
    end
    check(vref == CW'(3) && osc_en, "R8 reached mid ramp", int'(vref), 3);
    en = 1'b0;
    @(negedge clk);
    expect_idle("R8 enable drop mid ramp");
    uv = 1'b0;
    @(negedge clk);
    run_one(9, 1);

    finish_run();
  end
endmodule